// File: doc/BRIEF.md
# Multi-lane pipelined vector arithmetic unit

This block executes one element-wise integer vector instruction at a time. A single start pulse carries an operation code, two source vector register numbers, a destination register number and an element count. The unit then walks the elements in groups, one group per cycle. Each group holds as many elements as there are lanes, and element i belongs to lane i modulo the lane count. Every lane is a fixed-depth pipeline. Results go back to the vector register file through one write port per lane.

The register file sits outside the block. The unit puts out a group index and two register numbers on its read side. The file returns the addressed elements of both sources, one element per lane, within the same cycle. Elements of one instruction are independent, so there is no hazard or forwarding logic between them. A done pulse follows the last write once the lanes have drained. A count of zero finishes at once, and a start that arrives while an instruction is running is dropped.

Top module: `vec_lane_alu`

## Requirements
- R1: After reset, every lane write enable, the read enable and done are low.
- R2: Element i of the destination receives f(A[i], B[i]) truncated to ELEM_W bits, where the operation code selects f: 0 = A+B, 1 = A-B, 2 = low half of A*B, 3 = A xor B.
- R3: Element i is read and written by lane i mod LANES, in group i / LANES. Groups are read in ascending order, one per consecutive cycle, starting the cycle after start is sampled.
- R4: A group read in cycle t is written in cycle t+DEPTH (six with default parameters), with the destination number on the write register port and the group index on the write group port.
- R5: In the final group, a lane whose element index is not below the element count has its write enable low. Enabled lanes therefore always form a prefix starting at lane 0.
- R6: Done is a one-cycle pulse in the cycle after the write of the last group, that is, G+DEPTH+1 cycles after the start cycle, where G = ceil(count/LANES).
- R7: An element count of zero gives done in the cycle after start, with no read and no write.
- R8: An element count above MAX_VL is clamped to MAX_VL elements.
- R9: A start pulse while an instruction is in progress is ignored. The running instruction's writes, register numbers and done timing are unchanged.
- R10: The destination may equal a source. Every element is still computed from the source value held before the instruction started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one instruction |
| op_i | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 xor) |
| src_a_i | input | 4 | First source register number |
| src_b_i | input | 4 | Second source register number |
| dst_i | input | 4 | Destination register number |
| vl_i | input | 7 | Element count, clamped to MAX_VL |
| rd_en_o | output | 1 | A group is being read this cycle |
| rd_reg_a_o | output | 4 | Register number for source A read |
| rd_reg_b_o | output | 4 | Register number for source B read |
| rd_grp_o | output | 4 | Group index being read |
| rd_data_a_i | input | 64 | Source A elements of the group, lane 0 in the low bits |
| rd_data_b_i | input | 64 | Source B elements of the group, lane 0 in the low bits |
| wr_en_o | output | 4 | Per-lane write enable |
| wr_reg_o | output | 4 | Destination register number for writes |
| wr_grp_o | output | 4 | Group index being written |
| wr_data_o | output | 64 | Per-lane results, lane 0 in the low bits |
| done_o | output | 1 | Instruction complete pulse |

## Verification
Timing is counted from the cycle in which start is sampled, called offset 0. The read of group g is due at offset g+1, its write at offset g+7, and done at offset G+7, or at offset 1 for a zero count. The bench keeps a behavioural register file and snapshots both sources before each instruction. At every falling edge it predicts the read enable, the write enables, the register and group numbers, every lane's data and done for that exact offset, and compares them with the outputs. It continues one cycle past done so that any stray late write or second done pulse is caught.

// File: rtl/vla_pkg.sv
package vla_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2,
      OP_XOR = 2'd3
   } vla_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_DRAIN = 2'd2
   } vla_state_e;
endpackage

// File: rtl/vla_seq.sv
module vla_seq
   import vla_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int MAX_VL   = 64,
   parameter int LANES    = 4,
   localparam int RW      = $clog2(NUM_REGS),
   localparam int VLW     = $clog2(MAX_VL + 1),
   localparam int NGRP    = MAX_VL / LANES,
   localparam int GW      = (NGRP > 1) ? $clog2(NGRP) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic [RW-1:0]    src_a_i,
   input  logic [RW-1:0]    src_b_i,
   input  logic [RW-1:0]    dst_i,
   input  logic [VLW-1:0]   vl_i,
   input  logic             drain_last_i,
   output logic             iss_o,
   output logic [LANES-1:0] iss_mask_o,
   output logic             iss_last_o,
   output logic [GW-1:0]    grp_o,
   output vla_op_e          op_o,
   output logic [RW-1:0]    reg_a_o,
   output logic [RW-1:0]    reg_b_o,
   output logic [RW-1:0]    reg_d_o,
   output logic [VLW-1:0]   vl_act_o,
   output logic             done_o
);
   vla_state_e      state_q;
   logic [GW-1:0]   grp_q;
   logic [VLW-1:0]  vl_q;
   logic [VLW-1:0]  vl_eff;
   vla_op_e         op_q;
   logic [RW-1:0]   ra_q, rb_q, rd_q;
   logic            done_q;
   logic            accept;

   assign vl_eff = (int'(vl_i) > MAX_VL) ? VLW'(MAX_VL) : vl_i;
   assign accept = (state_q == SQ_IDLE) && start_i;
   assign iss_last_o = ((int'(grp_q) + 1) * LANES) >= int'(vl_q);

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign iss_mask_o[l] = (state_q == SQ_ISSUE) &&
                             ((int'(grp_q) * LANES + l) < int'(vl_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         grp_q   <= '0;
         vl_q    <= '0;
         op_q    <= OP_ADD;
         ra_q    <= '0;
         rb_q    <= '0;
         rd_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  op_q  <= vla_op_e'(op_i);
                  ra_q  <= src_a_i;
                  rb_q  <= src_b_i;
                  rd_q  <= dst_i;
                  vl_q  <= vl_eff;
                  grp_q <= '0;
                  if (vl_eff == '0) done_q  <= 1'b1;
                  else              state_q <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               if (iss_last_o) state_q <= SQ_DRAIN;
               else            grp_q   <= grp_q + 1'b1;
            end
            SQ_DRAIN: begin
               if (drain_last_i) begin
                  done_q  <= 1'b1;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign iss_o    = (state_q == SQ_ISSUE);
   assign grp_o    = grp_q;
   assign op_o     = op_q;
   assign reg_a_o  = ra_q;
   assign reg_b_o  = rb_q;
   assign reg_d_o  = rd_q;
   assign vl_act_o = vl_q;
   assign done_o   = done_q;

   // R9: a start seen mid-instruction leaves the latched instruction alone
   p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE && start_i) |=> ($stable(rd_q) && $stable(vl_q) && $stable(op_q)));

   // R7: an accepted zero-length instruction finishes next cycle without issuing
   p_zero_len_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && vl_eff == '0) |=> (done_o && !iss_o));
endmodule

// File: rtl/vla_lane.sv
module vla_lane
   import vla_pkg::*;
#(
   parameter int ELEM_W = 16,
   parameter int DEPTH  = 6,
   localparam int CW    = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  vla_op_e           op_i,
   input  logic [ELEM_W-1:0] a_i,
   input  logic [ELEM_W-1:0] b_i,
   output logic              out_valid_o,
   output logic [ELEM_W-1:0] out_data_o
);
   logic [ELEM_W-1:0] res;
   logic [ELEM_W-1:0] dat_q [DEPTH];
   logic [DEPTH-1:0]  vld_q;
   logic [CW-1:0]     idle_q;

   always_comb begin
      case (op_i)
         OP_ADD:  res = a_i + b_i;
         OP_SUB:  res = a_i - b_i;
         OP_MUL:  res = ELEM_W'(a_i * b_i);
         default: res = a_i ^ b_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int k = 0; k < DEPTH; k++) dat_q[k] <= '0;
      end else begin
         vld_q[0] <= in_valid_i;
         dat_q[0] <= res;
         for (int k = 1; k < DEPTH; k++) begin
            vld_q[k] <= vld_q[k-1];
            dat_q[k] <= dat_q[k-1];
         end
      end
   end

   assign out_valid_o = vld_q[DEPTH-1];
   assign out_data_o  = dat_q[DEPTH-1];

   // cycles since the last operand entered, saturating at DEPTH
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                idle_q <= CW'(DEPTH);
      else if (in_valid_i)       idle_q <= '0;
      else if (idle_q != CW'(DEPTH)) idle_q <= idle_q + 1'b1;
   end

   // R6: once DEPTH idle cycles have passed the lane has drained
   p_lane_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q == CW'(DEPTH)) |-> !out_valid_o);
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
   import vla_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int MAX_VL   = 64,
   parameter int LANES    = 4,
   parameter int ELEM_W   = 16,
   parameter int DEPTH    = 6,
   localparam int RW      = $clog2(NUM_REGS),
   localparam int VLW     = $clog2(MAX_VL + 1),
   localparam int NGRP    = MAX_VL / LANES,
   localparam int GW      = (NGRP > 1) ? $clog2(NGRP) : 1,
   localparam int DW      = LANES * ELEM_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic [RW-1:0]    src_a_i,
   input  logic [RW-1:0]    src_b_i,
   input  logic [RW-1:0]    dst_i,
   input  logic [VLW-1:0]   vl_i,
   output logic             rd_en_o,
   output logic [RW-1:0]    rd_reg_a_o,
   output logic [RW-1:0]    rd_reg_b_o,
   output logic [GW-1:0]    rd_grp_o,
   input  logic [DW-1:0]    rd_data_a_i,
   input  logic [DW-1:0]    rd_data_b_i,
   output logic [LANES-1:0] wr_en_o,
   output logic [RW-1:0]    wr_reg_o,
   output logic [GW-1:0]    wr_grp_o,
   output logic [DW-1:0]    wr_data_o,
   output logic             done_o
);
   if (LANES < 1 || (MAX_VL % LANES) != 0) begin : g_bad_lanes
      $error("vec_lane_alu: MAX_VL must be a multiple of LANES");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("vec_lane_alu: DEPTH must be at least one");
   end
   if (NUM_REGS < 2 || ELEM_W < 1) begin : g_bad_size
      $error("vec_lane_alu: register count or element width out of range");
   end

   logic             iss;
   logic [LANES-1:0] iss_mask;
   logic             iss_last;
   logic [GW-1:0]    grp;
   vla_op_e          op;
   logic [RW-1:0]    reg_d;
   logic [VLW-1:0]   vl_act;
   logic             drain_last;

   logic [DEPTH-1:0] tag_v_q;
   logic [DEPTH-1:0] tag_last_q;
   logic [GW-1:0]    tag_grp_q [DEPTH];

   vla_seq #(.NUM_REGS(NUM_REGS), .MAX_VL(MAX_VL), .LANES(LANES)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .op_i         (op_i),
      .src_a_i      (src_a_i),
      .src_b_i      (src_b_i),
      .dst_i        (dst_i),
      .vl_i         (vl_i),
      .drain_last_i (drain_last),
      .iss_o        (iss),
      .iss_mask_o   (iss_mask),
      .iss_last_o   (iss_last),
      .grp_o        (grp),
      .op_o         (op),
      .reg_a_o      (rd_reg_a_o),
      .reg_b_o      (rd_reg_b_o),
      .reg_d_o      (reg_d),
      .vl_act_o     (vl_act),
      .done_o       (done_o)
   );

   // group tag pipeline shared by all lanes, same depth as each lane
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_v_q    <= '0;
         tag_last_q <= '0;
         for (int k = 0; k < DEPTH; k++) tag_grp_q[k] <= '0;
      end else begin
         tag_v_q[0]    <= iss;
         tag_last_q[0] <= iss && iss_last;
         tag_grp_q[0]  <= grp;
         for (int k = 1; k < DEPTH; k++) begin
            tag_v_q[k]    <= tag_v_q[k-1];
            tag_last_q[k] <= tag_last_q[k-1];
            tag_grp_q[k]  <= tag_grp_q[k-1];
         end
      end
   end

   assign drain_last = tag_v_q[DEPTH-1] && tag_last_q[DEPTH-1];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      vla_lane #(.ELEM_W(ELEM_W), .DEPTH(DEPTH)) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .in_valid_i  (iss_mask[l]),
         .op_i        (op),
         .a_i         (rd_data_a_i[l*ELEM_W +: ELEM_W]),
         .b_i         (rd_data_b_i[l*ELEM_W +: ELEM_W]),
         .out_valid_o (wr_en_o[l]),
         .out_data_o  (wr_data_o[l*ELEM_W +: ELEM_W])
      );
      if (l > 0) begin : g_prefix
         // R5: an upper lane never writes unless the lane below it does
         p_lane_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_o[l] |-> wr_en_o[l-1]);
      end
   end

   assign rd_en_o  = iss;
   assign rd_grp_o = grp;
   assign wr_reg_o = reg_d;
   assign wr_grp_o = tag_grp_q[DEPTH-1];

   // R8: no write ever targets a group at or beyond the active count
   p_write_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en_o) |-> ((int'(wr_grp_o) * LANES) < int'(vl_act)));

   // R6: done only ever follows the drain of a last group or a zero count
   p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(drain_last) || ($past(start_i) && vl_act == '0)));
endmodule

// File: tb/vec_lane_alu_bench.sv
module vec_lane_alu_bench;
   localparam int NR = 16, MV = 64, LN = 4, EW = 16, DP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    op_i = '0;
   logic [3:0]    src_a_i = '0, src_b_i = '0, dst_i = '0;
   logic [6:0]    vl_i = '0;
   logic          rd_en_o;
   logic [3:0]    rd_reg_a_o, rd_reg_b_o, rd_grp_o;
   logic [63:0]   rd_data_a_i, rd_data_b_i;
   logic [3:0]    wr_en_o, wr_reg_o, wr_grp_o;
   logic [63:0]   wr_data_o;
   logic          done_o;

   always #2 clk = ~clk;

   vec_lane_alu u_vec_lane_alu (.*);

   int n_chk = 0, n_bad = 0;
   logic [15:0] rf [NR][MV];
   logic [15:0] snap_a [MV];
   logic [15:0] snap_b [MV];

   // behavioural register file
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NR; r++)
            for (int e = 0; e < MV; e++) rf[r][e] <= 16'(r * 4099 + e * 2731 + 17);
      end else begin
         for (int l = 0; l < LN; l++)
            if (wr_en_o[l]) rf[wr_reg_o][int'(wr_grp_o) * LN + l] <= wr_data_o[l*EW +: EW];
      end
   end

   always_comb begin
      for (int l = 0; l < LN; l++) begin
         rd_data_a_i[l*EW +: EW] = rf[rd_reg_a_o][int'(rd_grp_o) * LN + l];
         rd_data_b_i[l*EW +: EW] = rf[rd_reg_b_o][int'(rd_grp_o) * LN + l];
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_op(int op, logic [15:0] a, logic [15:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return 16'(a * b);
         default: return a ^ b;
      endcase
   endfunction

   // run one instruction; ign=1 pulses a second start mid-run (R9)
   task automatic run(int op, int ra, int rb, int rd, int vl, bit ign);
      int vle, g_cnt, kmax;
      vle   = (vl > MV) ? MV : vl;
      g_cnt = (vle + LN - 1) / LN;
      kmax  = g_cnt + DP + 2;
      for (int e = 0; e < MV; e++) begin
         snap_a[e] = rf[ra][e];
         snap_b[e] = rf[rb][e];
      end
      @(negedge clk);
      op_i = 2'(op); src_a_i = 4'(ra); src_b_i = 4'(rb); dst_i = 4'(rd);
      vl_i = 7'(vl); start_i = 1'b1;
      for (int k = 1; k <= kmax; k++) begin
         @(negedge clk);
         if (k == 1) start_i = 1'b0;
         if (ign && k == 3) begin
            start_i = 1'b1; dst_i = 4'((rd + 1) % NR); vl_i = 7'd5; op_i = 2'd3;
         end
         if (ign && k == 4) start_i = 1'b0;
         begin
            bit   exp_rd, exp_done;
            logic [3:0] exp_wen;
            int   wg;
            exp_rd   = (k >= 1 && k <= g_cnt);
            exp_done = (vle == 0) ? (k == 1) : (k == g_cnt + DP + 1);
            wg       = k - DP - 1;
            exp_wen  = '0;
            if (wg >= 0 && wg < g_cnt)
               for (int l = 0; l < LN; l++) exp_wen[l] = (wg * LN + l) < vle;
            chk(vle == 0 ? "R7" : "R3", "rd_en", rd_en_o, exp_rd);
            if (exp_rd) chk("R3", "rd_grp", rd_grp_o, k - 1);
            chk(vle == 0 ? "R7" : "R5", "wr_en", wr_en_o, exp_wen);
            chk(ign ? "R9" : "R6", "done", done_o, exp_done);
            if (exp_wen != '0) begin
               chk("R4", "wr_grp", wr_grp_o, wg);
               chk(ign ? "R9" : "R4", "wr_reg", wr_reg_o, rd);
               for (int l = 0; l < LN; l++)
                  if (exp_wen[l])
                     chk(ra == rd ? "R10" : (vl > MV ? "R8" : "R2"), "wr_data",
                         wr_data_o[l*EW +: EW],
                         ref_op(op, snap_a[wg*LN+l], snap_b[wg*LN+l]));
            end
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "wr_en at reset", wr_en_o, 0);
      chk("R1", "done at reset", done_o, 0);
      chk("R1", "rd_en at reset", rd_en_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "wr_en after reset", wr_en_o, 0);
      run(0, 1, 2, 3, 64, 0);    // R2 add, full length
      run(1, 4, 5, 6, 13, 0);    // R5 partial final group, sub
      run(2, 7, 8, 9, 3, 0);     // R5 single partial group, mul
      run(3, 1, 9, 1, 30, 0);    // R10 destination equals source, xor
      run(0, 2, 3, 10, 0, 0);    // R7 zero count
      run(2, 2, 3, 11, 100, 0);  // R8 count clamped
      run(0, 5, 6, 12, 20, 1);   // R9 start ignored while busy
      run(2, 11, 12, 13, 4, 0);  // R3 exactly one group
      run(1, 13, 13, 14, 1, 0);  // R5 one element only
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule